// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a burst request into the sequence of column addresses that a synchronous DRAM walks through during one read or write burst. A controller presents the starting column, the burst-length code, the ordering bit and a single-write flag taken from its mode register settings, then pulses a start strobe. From the next cycle on, the block emits one column per cycle with a valid strobe and marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned group of columns that holds the starting column, visited either by counting upward or by XOR with the beat number. A page-length burst counts through the whole row, wraps from the top column to column 0, and runs until the controller raises its stop input for a terminate or precharge. Reserved length codes, and page length combined with XOR ordering, are reported as illegal and start no burst. When the single-write flag is set, a write burst is reduced to one beat while reads keep the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_valid_o` and `last_o` are 0 until a legal start is accepted.
- R2: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. The first beat appears in the cycle after `start_i` is sampled, one beat follows per cycle, and `last_o` is 1 only on the final beat.
- R3: With `interleave_i` = 0, beat k of a fixed burst of length L has low log2(L) column bits equal to (start low bits + k) mod L. All higher column bits equal those of the starting column.
- R4: With `interleave_i` = 1, beat k of a fixed burst has low log2(L) column bits equal to the starting low bits XOR k. All higher column bits are unchanged.
- R5: Length code 3'b111 with `interleave_i` = 0 is a page burst. Its column goes up by one each cycle and wraps from the top column (1023 by default) to 0. It never raises `last_o` and keeps going until it is stopped.
- R6: `stop_i`, when sampled during a burst, ends it: no beat is valid in the following cycle. `stop_i` has no effect while idle.
- R7: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `interleave_i` = 1, set `illegal_o` to 1. A start with such a setting is ignored.
- R8: When `wr_single_i` = 1, a write (`is_write_i` = 1) is one beat long with `last_o` on that beat. A read keeps its programmed length.
- R9: A legal start accepted during a burst replaces it, even when `stop_i` is sampled on the same edge. The next cycle shows beat 0 of the new burst at the new starting column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the present settings |
| is_write_i | input | 1 | Burst is a write |
| col_i | input | COL_W | Starting column |
| bl_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 = XOR ordering, 0 = counting order |
| wr_single_i | input | 1 | Limit write bursts to one beat |
| stop_i | input | 1 | Terminate or precharge request; ends the running burst |
| col_o | output | COL_W | Column of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |
| illegal_o | output | 1 | Present length/ordering setting is not allowed |

## Verification
A new start can coincide with a stop, and it can also land on the final beat of a running burst. Both collide on the edge that decides whether the burst goes on. The bench raises start and stop together in the middle of an 8-beat burst, at a new column with XOR ordering. It expects beat 0 of the new burst on the next cycle and its four beats in XOR order after that, with nothing left over from the old burst. A page burst that crosses the top of the row and is then stopped covers the wrap and the stop together.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned LEN_W = 2;  // log2 of fixed length, 0..3
  localparam int unsigned BLK_LOG2 = 3;

  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } bl_code_e;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_pkg::*;
(
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             wr_single_i,
  input  logic             is_write_i,
  output logic [LEN_W-1:0] len_log2_o,
  output logic             full_o,
  output logic             illegal_o
);
  logic [LEN_W-1:0] prog_len;
  logic             prog_full;
  logic             bad_code;

  always_comb begin
    prog_len  = '0;
    prog_full = 1'b0;
    bad_code  = 1'b0;
    unique case (bl_code_i)
      BL_ONE:   prog_len = LEN_W'(0);
      BL_TWO:   prog_len = LEN_W'(1);
      BL_FOUR:  prog_len = LEN_W'(2);
      BL_EIGHT: prog_len = LEN_W'(3);
      BL_PAGE:  prog_full = 1'b1;
      default:  bad_code = 1'b1;
    endcase
  end

  // page length exists only in counting order
  assign illegal_o = bad_code | (prog_full & interleave_i);

  always_comb begin
    if (wr_single_i && is_write_i) begin
      len_log2_o = '0;
      full_o     = 1'b0;
    end else begin
      len_log2_o = prog_len;
      full_o     = prog_full;
    end
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [LEN_W-1:0] len_log2_i,
  input  logic             interleave_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + idx_i;  // wraps at the row size

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < BLK_LOG2) begin : g_low
      logic in_blk;
      assign in_blk = LEN_W'(b) < len_log2_i;
      always_comb begin
        if (full_i)                      col_o[b] = sum[b];
        else if (in_blk && interleave_i) col_o[b] = base_i[b] ^ idx_i[b];
        else if (in_blk)                 col_o[b] = sum[b];
        else                             col_o[b] = base_i[b];
      end
    end else begin : g_high
      assign col_o[b] = full_i ? sum[b] : base_i[b];
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             wr_single_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_o,
  output logic             illegal_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [LEN_W-1:0] dec_len;
  logic             dec_full;
  logic             go;

  logic             active_q;
  logic             full_q;
  logic             ilv_q;
  logic [LEN_W-1:0] len_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] blk_top;

  burst_mode_dec u_dec (
    .bl_code_i    (bl_code_i),
    .interleave_i (interleave_i),
    .wr_single_i  (wr_single_i),
    .is_write_i   (is_write_i),
    .len_log2_o   (dec_len),
    .full_o       (dec_full),
    .illegal_o    (illegal_o)
  );

  assign go = start_i & ~illegal_o;

  assign blk_top = (ONE << len_q) - ONE;
  assign last_o  = active_q & ~full_q & (idx_q == blk_top);
  assign beat_valid_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      len_q    <= '0;
      base_q   <= '0;
      idx_q    <= '0;
    end else if (go) begin
      // a new start outranks stop and the final beat
      active_q <= 1'b1;
      full_q   <= dec_full;
      ilv_q    <= interleave_i;
      len_q    <= dec_len;
      base_q   <= col_i;
      idx_q    <= '0;
    end else if (active_q) begin
      if (stop_i || last_o) active_q <= 1'b0;
      else                  idx_q    <= idx_q + ONE;
    end
  end

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base_i       (base_q),
    .idx_i        (idx_q),
    .len_log2_i   (len_q),
    .interleave_i (ilv_q),
    .full_i       (full_q),
    .col_o        (col_o)
  );

  a_r1_quiet_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !beat_valid_o && !last_o);

  a_r2_last_is_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o);

  a_r2_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !go) |=> !beat_valid_o);

  a_r3_block_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !full_q && !last_o && !stop_i && !go)
      |=> $stable(col_o[COL_W-1:BLK_LOG2]));

  a_r5_page_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && full_q && (col_o == '1) && !stop_i && !go)
      |=> beat_valid_o && (col_o == '0));

  a_r6_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !go) |=> !beat_valid_o);

  a_r7_illegal_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && illegal_o && !active_q) |=> !beat_valid_o);

  a_r9_start_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> beat_valid_o && (col_o == $past(col_i)));
endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/100ps
module tb_burst_col_gen;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             is_write_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       bl_code_i = 3'b000;
  logic             interleave_i = 1'b0;
  logic             wr_single_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_valid_o;
  logic             last_o;
  logic             illegal_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .is_write_i(is_write_i),
    .col_i(col_i), .bl_code_i(bl_code_i), .interleave_i(interleave_i),
    .wr_single_i(wr_single_i), .stop_i(stop_i), .col_o(col_o),
    .beat_valid_o(beat_valid_o), .last_o(last_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int k, int lg, bit ilv, bit full);
    int mask;
    int low;
    if (full) return (s + k) % (1 << COL_W);
    mask = (1 << lg) - 1;
    low  = ilv ? ((s & mask) ^ k) : ((s + k) & mask);
    return (s & ~mask) | low;
  endfunction

  task automatic drive_start(input logic [2:0] code, input bit ilv,
                             input int s, input bit wr, input bit ws);
    bl_code_i = code; interleave_i = ilv; col_i = COL_W'(s);
    is_write_i = wr; wr_single_i = ws; start_i = 1'b1;
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", beat_valid_o, 0);
    chk("R1 last", last_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", beat_valid_o, 0);
  endtask

  // R2 R3 R4 R8
  task automatic t_fixed(input string req, input logic [2:0] code, input bit ilv,
                         input int s, input bit wr, input bit ws,
                         input int beats, input int lg);
    @(negedge clk);
    drive_start(code, ilv, s, wr, ws);
    for (int k = 0; k < beats; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk({req, " valid"}, beat_valid_o, 1);
      chk({req, " col"}, col_o, exp_col(s, k, lg, ilv, 1'b0));
      chk({req, " last"}, last_o, (k == beats - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk({req, " idle"}, beat_valid_o, 0);
  endtask

  // R5 R6
  task automatic t_page();
    @(negedge clk);
    drive_start(3'b111, 1'b0, 1021, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk("R5 valid", beat_valid_o, 1);
      chk("R5 col", col_o, exp_col(1021, k, 0, 1'b0, 1'b1));
      chk("R5 no last", last_o, 0);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R6 stopped", beat_valid_o, 0);
  endtask

  // R6
  task automatic t_stop_idle();
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R6 idle stop", beat_valid_o, 0);
    t_fixed("R6 after idle stop", 3'b001, 1'b0, 7, 1'b0, 1'b0, 2, 1);
  endtask

  // R7
  task automatic t_illegal(input logic [2:0] code, input bit ilv);
    @(negedge clk);
    drive_start(code, ilv, 12, 1'b0, 1'b0);
    #1;
    chk("R7 flag", illegal_o, 1);
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 no burst", beat_valid_o, 0);
  endtask

  // R9
  task automatic t_restart();
    @(negedge clk);
    drive_start(3'b011, 1'b0, 5, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 old beat0", col_o, 5);
    @(negedge clk);
    chk("R9 old beat1", col_o, 6);
    drive_start(3'b010, 1'b1, 42, 1'b0, 1'b0);
    stop_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
      chk("R9 valid", beat_valid_o, 1);
      chk("R9 col", col_o, exp_col(42, k, 2, 1'b1, 1'b0));
      chk("R9 last", last_o, (k == 3) ? 1 : 0);
    end
    @(negedge clk);
    chk("R9 idle", beat_valid_o, 0);
  endtask

  initial begin
    t_reset();
    t_fixed("R2 len1", 3'b000, 1'b0, 9, 1'b0, 1'b0, 1, 0);
    t_fixed("R2 R3 len2", 3'b001, 1'b0, 3, 1'b0, 1'b0, 2, 1);
    t_fixed("R2 R3 len4", 3'b010, 1'b0, 6, 1'b0, 1'b0, 4, 2);
    t_fixed("R2 R3 len8", 3'b011, 1'b0, 1021, 1'b0, 1'b0, 8, 3);
    t_fixed("R4 len4", 3'b010, 1'b1, 201, 1'b0, 1'b0, 4, 2);
    t_fixed("R4 len8", 3'b011, 1'b1, 333, 1'b0, 1'b0, 8, 3);
    t_fixed("R8 write single", 3'b011, 1'b0, 77, 1'b1, 1'b1, 1, 0);
    t_fixed("R8 read keeps", 3'b011, 1'b0, 77, 1'b0, 1'b1, 8, 3);
    t_fixed("R8 write no flag", 3'b010, 1'b0, 77, 1'b1, 1'b0, 4, 2);
    t_page();
    t_stop_idle();
    t_illegal(3'b100, 1'b0);
    t_illegal(3'b101, 1'b0);
    t_illegal(3'b110, 1'b0);
    t_illegal(3'b111, 1'b1);
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule